// File: doc/BRIEF.md
# DMA Command Register Front End with One-Deep Queue

This block sits between a coprocessor's register bus and its DMA transfer sequencer. Software programs a local-memory address, a main-memory address and then one of two length registers. The length write commits the whole command: it goes to the sequencer at once when the engine is idle, or else waits in a single pending slot until the running transfer completes. Address writes go into a staging stage that stays invisible to reads. Reads always show the transfer that is running, or the last one that finished.

When the sequencer signals completion, it also returns the final addresses: one past the last 8-byte word moved. The block stores these, sets the length field to its end-of-transfer value and clears the row count. It then starts the queued command, if there is one. Two status outputs tell whether a transfer is running and whether one is queued.

Register select codes are 0 for the local address, 1 for the main address, 2 for the read length (main to local) and 3 for the write length (local to main).

Top module: `dma_cmd_regs`

## Requirements
- R1: After reset, all four registers read 0. busy_o, pending_o and start_o are 0.
- R2: Bits 2:0 always read 0. The local register reads bank (bit 12) and address (bits 11:3), with bits 31:13 at 0. The main register reads bits 23:3, with bits 31:24 at 0. A length register reads skip in bits 31:23, 0 in bits 22:20, row count minus one in bits 19:12 and bytes minus one in bits 11:3.
- R3: A write to select 0 or 1 changes no read value until a length write commits a transfer that uses it.
- R4: A length write while idle, with the slot empty, gives start_o = 1 and busy_o = 1 on the next cycle. The start_* fields then carry the staged addresses and the written length fields. start_to_main_o is 0 for select 2 and 1 for select 3. The register reads show the new command.
- R5: A length write while busy_o = 1 and done_i = 0 sets pending_o = 1 on the next cycle and gives no start pulse.
- R6: done_i with pending_o = 1 gives start_o = 1 on the next cycle with the queued command. pending_o then clears and busy_o stays 1.
- R7: done_i with busy_o = 1, pending_o = 0 and no length write clears busy_o on the next cycle. The address registers then read done_lcl_i and done_main_i with bits 2:0 forced to 0. The length field reads 0xFF8, the count reads 0 and the skip is kept.
- R8: A length write while a command is already queued replaces the queued command.
- R9: done_i while busy_o = 0 changes no register value and no status bit.
- R10: pending_o = 1 implies busy_o = 1. start_o is high for one cycle per transfer start.
- R11: A length write in the same cycle as done_i of a transfer with nothing queued starts the new command on the next cycle. With a command queued, the queued one starts and the new one becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 32 | Read data (combinational) |
| start_o | output | 1 | One-cycle transfer start pulse |
| start_to_main_o | output | 1 | Direction: 1 local to main, 0 main to local |
| start_lcl_o | output | 13 | Bank and local start address |
| start_main_o | output | 24 | Main-memory start address |
| start_len_o | output | 12 | Bytes per row minus one |
| start_cnt_o | output | 8 | Rows minus one |
| start_skip_o | output | 12 | Main-memory stride between rows |
| done_i | input | 1 | Transfer complete from sequencer |
| done_lcl_i | input | 13 | Final local address from sequencer |
| done_main_i | input | 24 | Final main address from sequencer |
| busy_o | output | 1 | Transfer running |
| pending_o | output | 1 | Transfer queued |

## Verification
The hardest cases are collisions at completion: a length write in the very cycle that done_i arrives, once with the slot empty and once with it full. Each one decides whether the new command starts straight away or only queues. The bench reaches both in a known state. It first starts a transfer, or starts one and queues a second. It then drives the length write and done_i in the same cycle. The queue overwrite case is reached in a similar way: two length writes are issued before any completion.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  parameter int unsigned DW     = 32;
  parameter int unsigned LCL_W  = 13;  // bank bit + 12-bit address
  parameter int unsigned MAIN_W = 24;
  parameter int unsigned LEN_W  = 12;
  parameter int unsigned CNT_W  = 8;
  parameter int unsigned ALIGN  = 3;   // 8-byte granularity
  localparam int unsigned CNT_LSB  = LEN_W;
  localparam int unsigned SKIP_LSB = LEN_W + CNT_W;

  typedef enum logic [1:0] {
    REG_LCL   = 2'd0,
    REG_MAIN  = 2'd1,
    REG_RDLEN = 2'd2,
    REG_WRLEN = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                    to_main;
    logic [LCL_W-1:ALIGN]    lcl;
    logic [MAIN_W-1:ALIGN]   main;
    logic [LEN_W-1:ALIGN]    len;
    logic [CNT_W-1:0]        cnt;
    logic [LEN_W-1:ALIGN]    skip;
  } cmd_t;
endpackage

// File: rtl/dma_stage.sv
module dma_stage import dma_regs_pkg::*; (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_lcl_i,
  input  logic                  we_main_i,
  input  logic [DW-1:0]         data_i,
  output logic [LCL_W-1:ALIGN]  lcl_o,
  output logic [MAIN_W-1:ALIGN] main_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcl_o  <= '0;
      main_o <= '0;
    end else begin
      if (we_lcl_i)  lcl_o  <= data_i[LCL_W-1:ALIGN];
      if (we_main_i) main_o <= data_i[MAIN_W-1:ALIGN];
    end
  end
endmodule

// File: rtl/dma_slot.sv
module dma_slot import dma_regs_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  cmd_t cmd_i,
  output logic valid_o,
  output cmd_t cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cmd_o   <= '0;
    end else if (push_i) begin  // push wins: overwrite, or refill after pop
      valid_o <= 1'b1;
      cmd_o   <= cmd_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_queue_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> valid_o);
  assert_queue_replace_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> cmd_o == $past(cmd_i));
endmodule

// File: rtl/dma_active.sv
module dma_active import dma_regs_pkg::*; (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  len_wr_i,
  input  cmd_t                  new_cmd_i,
  input  logic                  done_i,
  input  logic [LCL_W-1:0]      done_lcl_i,
  input  logic [MAIN_W-1:0]     done_main_i,
  input  logic                  slot_valid_i,
  input  cmd_t                  slot_cmd_i,
  output logic                  push_o,
  output logic                  pop_o,
  output logic                  busy_o,
  output logic                  start_o,
  output cmd_t                  act_o
);
  logic fin, busy_after, direct;

  always_comb begin
    fin        = done_i & busy_o;
    busy_after = fin ? slot_valid_i : busy_o;
    pop_o      = fin & slot_valid_i;
    direct     = len_wr_i & ~busy_after;
    push_o     = len_wr_i & busy_after;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      act_o   <= '0;
    end else begin
      start_o <= direct | pop_o;
      if (direct) begin
        act_o  <= new_cmd_i;
        busy_o <= 1'b1;
      end else if (pop_o) begin
        act_o  <= slot_cmd_i;
      end else if (fin) begin
        act_o.lcl  <= done_lcl_i[LCL_W-1:ALIGN];
        act_o.main <= done_main_i[MAIN_W-1:ALIGN];
        act_o.len  <= '1;  // reads as all-ones minus 7
        act_o.cnt  <= '0;
        busy_o     <= 1'b0;
      end
    end
  end

  assert_queue_needs_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i |-> busy_o);
  assert_start_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  assert_promote_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> start_o && act_o == $past(slot_cmd_i));
  assert_writeback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && busy_o && !slot_valid_i && !len_wr_i |=> !busy_o && act_o.len == '1 && act_o.cnt == '0);
  assert_idle_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !busy_o && !len_wr_i |=> $stable(act_o) && !busy_o);
  assert_collide_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && busy_o && !slot_valid_i && len_wr_i |=> start_o && act_o == $past(new_cmd_i));
endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs import dma_regs_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              start_o,
  output logic              start_to_main_o,
  output logic [LCL_W-1:0]  start_lcl_o,
  output logic [MAIN_W-1:0] start_main_o,
  output logic [LEN_W-1:0]  start_len_o,
  output logic [CNT_W-1:0]  start_cnt_o,
  output logic [LEN_W-1:0]  start_skip_o,
  input  logic              done_i,
  input  logic [LCL_W-1:0]  done_lcl_i,
  input  logic [MAIN_W-1:0] done_main_i,
  output logic              busy_o,
  output logic              pending_o
);
  logic [LCL_W-1:ALIGN]  stage_lcl;
  logic [MAIN_W-1:ALIGN] stage_main;
  logic len_wr, push, pop;
  cmd_t new_cmd, slot_cmd, act;

  dma_stage i_stage (
    .clk_i, .rst_ni,
    .we_lcl_i  (wr_en_i && wr_sel_i == REG_LCL),
    .we_main_i (wr_en_i && wr_sel_i == REG_MAIN),
    .data_i    (wr_data_i),
    .lcl_o     (stage_lcl),
    .main_o    (stage_main)
  );

  assign len_wr = wr_en_i & wr_sel_i[1];

  always_comb begin
    new_cmd.to_main = (wr_sel_i == REG_WRLEN);
    new_cmd.lcl     = stage_lcl;
    new_cmd.main    = stage_main;
    new_cmd.len     = wr_data_i[LEN_W-1:ALIGN];
    new_cmd.cnt     = wr_data_i[SKIP_LSB-1:CNT_LSB];
    new_cmd.skip    = wr_data_i[SKIP_LSB+LEN_W-1:SKIP_LSB+ALIGN];
  end

  dma_slot i_slot (
    .clk_i, .rst_ni,
    .push_i  (push),
    .pop_i   (pop),
    .cmd_i   (new_cmd),
    .valid_o (pending_o),
    .cmd_o   (slot_cmd)
  );

  dma_active i_active (
    .clk_i, .rst_ni,
    .len_wr_i     (len_wr),
    .new_cmd_i    (new_cmd),
    .done_i,
    .done_lcl_i,
    .done_main_i,
    .slot_valid_i (pending_o),
    .slot_cmd_i   (slot_cmd),
    .push_o       (push),
    .pop_o        (pop),
    .busy_o,
    .start_o,
    .act_o        (act)
  );

  assign start_to_main_o = act.to_main;
  assign start_lcl_o     = {act.lcl,  {ALIGN{1'b0}}};
  assign start_main_o    = {act.main, {ALIGN{1'b0}}};
  assign start_len_o     = {act.len,  {ALIGN{1'b0}}};
  assign start_cnt_o     = act.cnt;
  assign start_skip_o    = {act.skip, {ALIGN{1'b0}}};

  always_comb begin
    rd_data_o = '0;
    case (reg_sel_e'(rd_sel_i))
      REG_LCL:  rd_data_o[LCL_W-1:0]  = start_lcl_o;
      REG_MAIN: rd_data_o[MAIN_W-1:0] = start_main_o;
      default: begin
        rd_data_o[LEN_W-1:0]                 = start_len_o;
        rd_data_o[SKIP_LSB-1:CNT_LSB]        = start_cnt_o;
        rd_data_o[SKIP_LSB+LEN_W-1:SKIP_LSB] = start_skip_o;
      end
    endcase
  end

  assert_aligned_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[ALIGN-1:0] == '0);
  assert_no_start_when_queued_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_wr && busy_o && !done_i |=> !start_o && pending_o);
endmodule

// File: tb/test_dma_cmd_regs.sv
`timescale 1ns/1ps
module test_dma_cmd_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, done = 1'b0;
  logic [1:0] wsel = '0, rsel = '0;
  logic [31:0] wdata = '0, rdata;
  logic [12:0] dlcl = '0, s_lcl;
  logic [23:0] dmain = '0, s_main;
  logic [11:0] s_len, s_skip;
  logic [7:0] s_cnt;
  logic s_start, s_dir, busy, pend;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_cmd_regs i_dma_cmd_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wdata),
    .rd_sel_i(rsel), .rd_data_o(rdata), .start_o(s_start), .start_to_main_o(s_dir),
    .start_lcl_o(s_lcl), .start_main_o(s_main), .start_len_o(s_len), .start_cnt_o(s_cnt),
    .start_skip_o(s_skip), .done_i(done), .done_lcl_i(dlcl), .done_main_i(dmain),
    .busy_o(busy), .pending_o(pend));

  // reference model: 32-bit register images
  localparam logic [31:0] M_LCL = 32'h0000_1FF8, M_MAIN = 32'h00FF_FFF8, M_LEN = 32'hFF8F_FFF8;
  logic [31:0] m_r0 = 0, m_r1 = 0, m_len = 0, s0 = 0, s1 = 0, p0 = 0, p1 = 0, plen = 0;
  logic m_dir = 0, pdir = 0, m_pv = 0, m_busy = 0, m_start = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r0 = 0; m_r1 = 0; m_len = 0; s0 = 0; s1 = 0; m_dir = 0;
      m_pv = 0; m_busy = 0; m_start = 0;
    end else begin
      m_start = 0;
      if (done && m_busy) begin
        if (m_pv) begin
          m_r0 = p0; m_r1 = p1; m_len = plen; m_dir = pdir; m_pv = 0; m_start = 1;
        end else begin
          m_r0 = {19'b0, dlcl} & M_LCL; m_r1 = {8'b0, dmain} & M_MAIN;
          m_len = (m_len & 32'hFFF0_0000) | 32'h0000_0FF8; m_busy = 0;
        end
      end
      if (we) begin
        if (wsel == 2'd0) s0 = wdata & M_LCL;
        else if (wsel == 2'd1) s1 = wdata & M_MAIN;
        else if (!m_busy) begin
          m_r0 = s0; m_r1 = s1; m_len = wdata & M_LEN; m_dir = wsel[0];
          m_busy = 1; m_start = 1;
        end else begin
          p0 = s0; p1 = s1; plen = wdata & M_LEN; pdir = wsel[0]; m_pv = 1;
        end
      end
    end
  end

  function automatic logic [31:0] mread(input logic [1:0] a);
    return (a == 2'd0) ? m_r0 : (a == 2'd1) ? m_r1 : m_len;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R7 busy", {31'b0, busy}, {31'b0, m_busy});
      chk("R5 pending", {31'b0, pend}, {31'b0, m_pv});
      chk("R10 start pulse", {31'b0, s_start}, {31'b0, m_start});
      if (m_start) begin
        chk("R4 start dir", {31'b0, s_dir}, {31'b0, m_dir});
        chk("R4 start lcl", {19'b0, s_lcl}, m_r0);
        chk("R4 start main", {8'b0, s_main}, m_r1);
        chk("R4 start len", {20'b0, s_len}, {20'b0, m_len[11:0]});
        chk("R4 start cnt", {24'b0, s_cnt}, {24'b0, m_len[19:12]});
        chk("R4 start skip", {20'b0, s_skip}, {20'b0, m_len[31:20]});
      end
    end
  end

  task automatic step(input logic w, input logic [1:0] sel, input logic [31:0] d,
                      input logic dn, input logic [12:0] dl, input logic [23:0] dm);
    we = w; wsel = sel; wdata = d; done = dn; dlcl = dl; dmain = dm;
    @(negedge clk);
    we = 0; done = 0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] a);
    rsel = a; #0.5;
    chk(tag, rdata, mread(a));
  endtask

  task automatic rall(input string tag);
    rchk(tag, 2'd0); rchk(tag, 2'd1); rchk(tag, 2'd2);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rall("R1 reset read");
    chk("R1 reset status", {30'b0, busy, pend}, 32'd0);

    step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0);
    rchk("R3 staged lcl hidden", 2'd0); rchk("R3 staged main hidden", 2'd1);
    chk("R3 literal", rdata, 32'd0);

    step(1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0);  // idle start, read direction
    rall("R2 aligned read");
    chk("R2 lcl literal", mread(2'd0), 32'h0000_1FF8);
    rchk("R2 len image", 2'd2);
    chk("R2 len literal", rdata, 32'hFF8F_FFF8);

    step(1, 2'd0, 32'h0000_0105, 0, 0, 0);
    step(1, 2'd1, 32'h0012_3457, 0, 0, 0);
    rall("R3 hidden while busy");
    step(1, 2'd3, 32'h0103_2017, 0, 0, 0);   // queued
    step(1, 2'd3, 32'h0200_5008, 0, 0, 0);   // overwrite queue R8
    chk("R8 still pending", {31'b0, pend}, 32'd1);
    step(0, 2'd0, 0, 1, 13'h1234, 24'hABCDEF);  // promote R6
    rall("R6 promoted read");
    step(0, 2'd0, 0, 1, 13'h0ABF, 24'h00F00D);  // finish, nothing queued R7
    rall("R7 writeback read");
    rchk("R7 len end", 2'd2);
    chk("R7 len literal", rdata & 32'h000F_FFFF, 32'h0000_0FF8);
    step(0, 2'd0, 0, 1, 13'h1FFF, 24'hFFFFFF);  // idle done R9
    rall("R9 idle done");
    chk("R9 status", {30'b0, busy, pend}, 32'd0);

    // R11 collision, empty queue
    step(1, 2'd0, 32'h0000_0040, 0, 0, 0);
    step(1, 2'd2, 32'h0000_0018, 0, 0, 0);
    step(1, 2'd1, 32'h0000_0800, 0, 0, 0);
    step(1, 2'd3, 32'h0301_1028, 1, 13'h0048, 24'h000100);
    rall("R11 direct start");
    // R11 collision, full queue
    step(1, 2'd2, 32'h0000_0030, 0, 0, 0);
    step(1, 2'd3, 32'h0000_0038, 1, 13'h0111, 24'h000222);
    chk("R11 queue refilled", {30'b0, busy, pend}, 32'd3);
    rall("R11 promoted");
    step(0, 2'd0, 0, 1, 13'h0333, 24'h000444);
    step(0, 2'd0, 0, 1, 13'h0555, 24'h000666);
    rall("R7 final writeback");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule